// File: doc/BRIEF.md
# LCD Common-Row Scan Driver Core

This block is the logic core of a dot-matrix LCD row (common) driver. A long scan register carries a select token, one stage per load tick, and each stage owns one common output. The token can travel toward the high-numbered stages or toward stage 0. The register can also run as two independent halves, where a middle input starts the second half. Several drivers chain together: the carry end of one device feeds the scan input end of the next, and the two end pins swap roles when the direction changes.

For every stage the block produces a 2-bit level code that picks one of four panel drive levels. The code depends on whether the stage holds the token, on a frame-alternation input that reverses polarity every frame, and on a display-off input that overrides everything. The level shifters and analog switches that turn these codes into voltages are outside this block.

Top module: `lcd_row_scan`

## Requirements
- R1: With `rst` high at a rising edge of `clk`, every stage is cleared. From the next cycle no stage is selected, and both `leftOut` and `rightOut` are 0.
- R2: With `dirRight`=1, `splitMode`=0 and `loadTick`=1, a clock edge moves stage i into stage i+1 and loads `leftIn` into stage 0.
- R3: With `dirRight`=0, `splitMode`=0 and `loadTick`=1, a clock edge moves stage i+1 into stage i and loads `rightIn` into the last stage.
- R4: With `loadTick`=0 the register holds its contents, whatever the scan and middle inputs do.
- R5: With `splitMode`=1, stage N/2 loads `midIn` when shifting upward, and stage N/2-1 loads `midIn` when shifting downward. No data crosses between the two halves.
- R6: With `dirRight`=1 the right pin is the output (`rightOe`=1, `leftOe`=0, `leftOut`=0). With `dirRight`=0 the roles are mirrored (`leftOe`=1, `rightOe`=0, `rightOut`=0).
- R7: The carry output on the output-role pin equals the last stage in the shift direction: stage N-1 upward, stage 0 downward. A token loaded on one tick therefore appears on the carry after N ticks, or after N/2 ticks from `midIn` in split mode.
- R8: Each stage i drives `levelCode[2i+1:2i]`. A selected stage with `frameAlt`=1 gives 2'b00 (top level). Selected with `frameAlt`=0 gives 2'b11 (bottom level). Unselected with `frameAlt`=1 gives 2'b10 (lower-middle level). Unselected with `frameAlt`=0 gives 2'b01 (upper-middle level).
- R9: With `dispOff`=1 every code is 2'b11, while the register keeps shifting. When `dispOff` is released, the codes show the shifted contents.
- R10: The codes follow `frameAlt` and `dispOff` in the same cycle they change, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadTick | input | 1 | Advance the scan register by one stage |
| dirRight | input | 1 | 1: shift toward high stages; 0: toward stage 0 |
| splitMode | input | 1 | Run as two independent halves |
| leftIn | input | 1 | Left end pin, scan input when `dirRight`=1 |
| rightIn | input | 1 | Right end pin, scan input when `dirRight`=0 |
| midIn | input | 1 | Scan input of the second half in split mode |
| frameAlt | input | 1 | Frame polarity |
| dispOff | input | 1 | Force all codes to the bottom level |
| leftOut | output | 1 | Left end pin drive value (carry when `dirRight`=0) |
| leftOe | output | 1 | Left end pin output enable |
| rightOut | output | 1 | Right end pin drive value (carry when `dirRight`=1) |
| rightOe | output | 1 | Right end pin output enable |
| levelCode | output | 2*NUM_STAGES | Per-stage drive level codes |

## Verification
A single token is walked across the whole register in each direction. This separates a correct neighbour chain from an off-by-one or reversed one, and it shows when the carry appears at the far end. Multi-bit patterns (1011) show that adjacent stages do not merge or drop bits. Split-mode runs inject on the end pin and on the middle pin together, which shows whether the halves leak into each other at the boundary. All four combinations of select and polarity, plus display-off with shifting underneath, are checked without clock edges to show the code mapping is immediate.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    LVL_TOP    = 2'b00,
    LVL_UPPER  = 2'b01,
    LVL_LOWER  = 2'b10,
    LVL_BOTTOM = 2'b11
  } drive_lvl_e;

  typedef struct packed {
    logic clear;
    logic advance;
    logic toHigh;
    logic split;
  } scan_ctl_t;

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
(
  input  logic      rst,
  input  logic      loadTick,
  input  logic      dirRight,
  input  logic      splitMode,
  input  logic      carryBit,
  output scan_ctl_t ctl,
  output logic      leftOut,
  output logic      leftOe,
  output logic      rightOut,
  output logic      rightOe
);

  always_comb begin
    ctl.clear   = rst;
    ctl.advance = loadTick & ~rst;
    ctl.toHigh  = dirRight;
    ctl.split   = splitMode;
  end

  // End pin roles: the carry end drives, the scan end is an input and its
  // output value is parked low.
  always_comb begin
    rightOe  = dirRight;
    leftOe   = ~dirRight;
    rightOut = dirRight ? carryBit : 1'b0;
    leftOut  = dirRight ? 1'b0 : carryBit;
  end

endmodule

// File: rtl/lcd_scan_shift.sv
module lcd_scan_shift
  import lcd_scan_pkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                  clk,
  input  scan_ctl_t             ctl,
  input  logic                  leftIn,
  input  logic                  rightIn,
  input  logic                  midIn,
  output logic [NUM_STAGES-1:0] stageQ,
  output logic                  carryBit
);

  localparam int HALF = NUM_STAGES / 2;
  localparam int LAST = NUM_STAGES - 1;

  logic headIn;
  assign headIn = ctl.toHigh ? leftIn : rightIn;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic upSrc;
    logic downSrc;

    if (i == 0) begin : g_up_head
      assign upSrc = headIn;
    end else if (i == HALF) begin : g_up_mid
      assign upSrc = ctl.split ? midIn : stageQ[i-1];
    end else begin : g_up_chain
      assign upSrc = stageQ[i-1];
    end

    if (i == LAST) begin : g_dn_head
      assign downSrc = headIn;
    end else if (i == HALF - 1) begin : g_dn_mid
      assign downSrc = ctl.split ? midIn : stageQ[i+1];
    end else begin : g_dn_chain
      assign downSrc = stageQ[i+1];
    end

    always_ff @(posedge clk) begin
      if (ctl.clear)
        stageQ[i] <= 1'b0;
      else if (ctl.advance)
        stageQ[i] <= ctl.toHigh ? upSrc : downSrc;
    end
  end

  assign carryBit = ctl.toHigh ? stageQ[LAST] : stageQ[0];

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_scan_pkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                    frameAlt,
  input  logic                    dispOff,
  input  logic [NUM_STAGES-1:0]   stageQ,
  output logic [2*NUM_STAGES-1:0] levelCode
);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_map
    drive_lvl_e lvl;
    always_comb begin
      if (dispOff)
        lvl = LVL_BOTTOM;
      else if (stageQ[i])
        lvl = frameAlt ? LVL_TOP : LVL_BOTTOM;
      else
        lvl = frameAlt ? LVL_LOWER : LVL_UPPER;
    end
    assign levelCode[2*i +: 2] = lvl;
  end

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    loadTick,
  input  logic                    dirRight,
  input  logic                    splitMode,
  input  logic                    leftIn,
  input  logic                    rightIn,
  input  logic                    midIn,
  input  logic                    frameAlt,
  input  logic                    dispOff,
  output logic                    leftOut,
  output logic                    leftOe,
  output logic                    rightOut,
  output logic                    rightOe,
  output logic [2*NUM_STAGES-1:0] levelCode
);

  scan_ctl_t             ctl;
  logic                  carryBit;
  logic [NUM_STAGES-1:0] stageQ;

  lcd_scan_ctrl u_ctrl (
    .rst       (rst),
    .loadTick  (loadTick),
    .dirRight  (dirRight),
    .splitMode (splitMode),
    .carryBit  (carryBit),
    .ctl       (ctl),
    .leftOut   (leftOut),
    .leftOe    (leftOe),
    .rightOut  (rightOut),
    .rightOe   (rightOe)
  );

  lcd_scan_shift #(.NUM_STAGES(NUM_STAGES)) u_shift (
    .clk      (clk),
    .ctl      (ctl),
    .leftIn   (leftIn),
    .rightIn  (rightIn),
    .midIn    (midIn),
    .stageQ   (stageQ),
    .carryBit (carryBit)
  );

  lcd_level_map #(.NUM_STAGES(NUM_STAGES)) u_map (
    .frameAlt  (frameAlt),
    .dispOff   (dispOff),
    .stageQ    (stageQ),
    .levelCode (levelCode)
  );

endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int NUM_STAGES = 240
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    loadTick,
  input logic                    dirRight,
  input logic                    splitMode,
  input logic                    leftIn,
  input logic                    rightIn,
  input logic                    midIn,
  input logic                    dispOff,
  input logic                    leftOut,
  input logic                    leftOe,
  input logic                    rightOut,
  input logic                    rightOe,
  input logic [NUM_STAGES-1:0]   stageQ,
  input logic [2*NUM_STAGES-1:0] levelCode
);

  localparam int HALF = NUM_STAGES / 2;
  localparam int LAST = NUM_STAGES - 1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (stageQ == '0));

  p_shift_up_r2: assert property (@(posedge clk) disable iff (rst)
    (loadTick && dirRight && !splitMode) |=>
      (stageQ == {$past(stageQ[LAST-1:0]), $past(leftIn)}));

  p_shift_down_r3: assert property (@(posedge clk) disable iff (rst)
    (loadTick && !dirRight && !splitMode) |=>
      (stageQ == {$past(rightIn), $past(stageQ[LAST:1])}));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !loadTick |=> (stageQ == $past(stageQ)));

  p_mid_up_r5: assert property (@(posedge clk) disable iff (rst)
    (loadTick && dirRight && splitMode) |=> (stageQ[HALF] == $past(midIn)));

  p_mid_down_r5: assert property (@(posedge clk) disable iff (rst)
    (loadTick && !dirRight && splitMode) |=> (stageQ[HALF-1] == $past(midIn)));

  p_pin_role_r6: assert property (@(posedge clk) disable iff (rst)
    dirRight ? (rightOe && !leftOe && !leftOut) : (leftOe && !rightOe && !rightOut));

  p_carry_r7: assert property (@(posedge clk) disable iff (rst)
    dirRight ? (rightOut == stageQ[LAST]) : (leftOut == stageQ[0]));

  p_dispoff_r9: assert property (@(posedge clk) disable iff (rst)
    dispOff |-> (levelCode == '1));

endmodule

bind lcd_row_scan lcd_row_scan_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loadTick  (loadTick),
  .dirRight  (dirRight),
  .splitMode (splitMode),
  .leftIn    (leftIn),
  .rightIn   (rightIn),
  .midIn     (midIn),
  .dispOff   (dispOff),
  .leftOut   (leftOut),
  .leftOe    (leftOe),
  .rightOut  (rightOut),
  .rightOe   (rightOe),
  .stageQ    (stageQ),
  .levelCode (levelCode)
);

// File: tb/lcd_row_scan_test.sv
`timescale 1ns/1ps
module lcd_row_scan_test;

  localparam int N = 240;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadTick = 1'b0;
  logic dirRight = 1'b1;
  logic splitMode = 1'b0;
  logic leftIn = 1'b0;
  logic rightIn = 1'b0;
  logic midIn = 1'b0;
  logic frameAlt = 1'b1;
  logic dispOff = 1'b0;
  logic leftOut, leftOe, rightOut, rightOe;
  logic [2*N-1:0] levelCode;

  int nChecks = 0;
  int nFails = 0;
  logic [N-1:0] mdl = '0;

  always #2 clk = ~clk;

  lcd_row_scan #(.NUM_STAGES(N)) uut (
    .clk(clk), .rst(rst), .loadTick(loadTick), .dirRight(dirRight),
    .splitMode(splitMode), .leftIn(leftIn), .rightIn(rightIn), .midIn(midIn),
    .frameAlt(frameAlt), .dispOff(dispOff), .leftOut(leftOut), .leftOe(leftOe),
    .rightOut(rightOut), .rightOe(rightOe), .levelCode(levelCode)
  );

  function automatic logic [N-1:0] nextState(logic [N-1:0] q, logic up, logic sp,
                                             logic hd, logic md);
    logic [N-1:0] r;
    if (up) begin
      r = {q[N-2:0], hd};
      if (sp) r[H] = md;
    end else begin
      r = {hd, q[N-1:1]};
      if (sp) r[H-1] = md;
    end
    return r;
  endfunction

  function automatic logic [2*N-1:0] expCodes(logic [N-1:0] q, logic alt, logic off);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) begin
      if (off)       v[2*i +: 2] = 2'b11;
      else if (q[i]) v[2*i +: 2] = alt ? 2'b00 : 2'b11;
      else           v[2*i +: 2] = alt ? 2'b10 : 2'b01;
    end
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    if (rst) mdl = '0;
    else if (loadTick)
      mdl = nextState(mdl, dirRight, splitMode, dirRight ? leftIn : rightIn, midIn);
    #1;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic chkCodes(input string tag);
    logic [2*N-1:0] e;
    e = expCodes(mdl, frameAlt, dispOff);
    nChecks++;
    if (levelCode !== e) begin
      nFails++;
      $display("FAIL %s levelCode actual=%h expected=%h", tag, levelCode, e);
    end
  endtask

  task automatic chkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tReset();
    rst = 1'b1; loadTick = 1'b1; leftIn = 1'b1;
    steps(2);
    rst = 1'b0; loadTick = 1'b0; leftIn = 1'b0;
    chkCodes("R1 reset codes");
    chkBit("R1 reset leftOut", leftOut, 1'b0);
    chkBit("R1 reset rightOut", rightOut, 1'b0);
  endtask

  task automatic tShiftUp();
    dirRight = 1'b1; splitMode = 1'b0; loadTick = 1'b1;
    leftIn = 1'b1; step();
    leftIn = 1'b0;
    chkCodes("R2 token at stage 0");
    chkBit("R6 up leftOe", leftOe, 1'b0);
    chkBit("R6 up rightOe", rightOe, 1'b1);
    chkBit("R6 up leftOut", leftOut, 1'b0);
    steps(5);
    chkCodes("R2 token at stage 5");
    steps(N - 7);
    chkBit("R7 up carry before end", rightOut, 1'b0);
    step();
    chkCodes("R2 token at last stage");
    chkBit("R7 up carry at N ticks", rightOut, 1'b1);
    step();
    chkBit("R7 up carry drops", rightOut, 1'b0);
    chkCodes("R2 token gone");
    leftIn = 1'b1; step(); leftIn = 1'b0; step();
    leftIn = 1'b1; step(); step(); leftIn = 1'b0;
    steps(3);
    chkCodes("R2 pattern 1011");
  endtask

  task automatic tHold();
    logic [2*N-1:0] snap;
    snap = levelCode;
    loadTick = 1'b0; leftIn = 1'b1; rightIn = 1'b1; midIn = 1'b1;
    steps(6);
    nChecks++;
    if (levelCode !== snap) begin
      nFails++;
      $display("FAIL R4 hold actual=%h expected=%h", levelCode, snap);
    end
    chkCodes("R4 hold model");
    leftIn = 1'b0; rightIn = 1'b0; midIn = 1'b0;
  endtask

  task automatic tShiftDown();
    rst = 1'b1; step(); rst = 1'b0;
    dirRight = 1'b0; splitMode = 1'b0; loadTick = 1'b1;
    rightIn = 1'b1; step(); rightIn = 1'b0;
    chkCodes("R3 token at last stage");
    chkBit("R6 down leftOe", leftOe, 1'b1);
    chkBit("R6 down rightOe", rightOe, 1'b0);
    chkBit("R6 down rightOut", rightOut, 1'b0);
    steps(9);
    chkCodes("R3 token moved 9");
    steps(N - 11);
    chkBit("R7 down carry before end", leftOut, 1'b0);
    step();
    chkBit("R7 down carry at N ticks", leftOut, 1'b1);
    chkCodes("R3 token at stage 0");
    rightIn = 1'b1; step(); step(); rightIn = 1'b0; step();
    rightIn = 1'b1; step(); rightIn = 1'b0;
    steps(4);
    chkCodes("R3 pattern");
  endtask

  task automatic tSplit();
    rst = 1'b1; step(); rst = 1'b0;
    dirRight = 1'b1; splitMode = 1'b1; loadTick = 1'b1;
    leftIn = 1'b1; midIn = 1'b1; step(); leftIn = 1'b0; midIn = 1'b0;
    chkCodes("R5 up injections");
    steps(H - 2);
    chkBit("R7 split carry early", rightOut, 1'b0);
    step();
    chkCodes("R5 up halves at ends");
    chkBit("R7 split carry at H ticks", rightOut, 1'b1);
    step();
    chkCodes("R5 up no crossing");
    rst = 1'b1; step(); rst = 1'b0;
    dirRight = 1'b0;
    rightIn = 1'b1; midIn = 1'b1; step(); rightIn = 1'b0; midIn = 1'b0;
    chkCodes("R5 down injections");
    steps(H - 1);
    chkBit("R7 split down carry", leftOut, 1'b1);
    step();
    chkCodes("R5 down no crossing");
    splitMode = 1'b0;
  endtask

  task automatic tCodes();
    rst = 1'b1; step(); rst = 1'b0;
    dirRight = 1'b1; loadTick = 1'b1;
    leftIn = 1'b1; step(); leftIn = 1'b0; step();
    loadTick = 1'b0;
    frameAlt = 1'b1; #1;
    chkCodes("R8 alt high");
    frameAlt = 1'b0; #1;
    chkCodes("R10 alt low immediate");
    chkBit("R8 selected alt low bit1", levelCode[3], 1'b1);
    chkBit("R8 unselected alt low bit1", levelCode[1], 1'b0);
    frameAlt = 1'b1; #1;
    chkBit("R8 selected alt high bit1", levelCode[3], 1'b0);
    chkBit("R8 unselected alt high bit1", levelCode[1], 1'b1);
  endtask

  task automatic tDispOff();
    dispOff = 1'b1; #1;
    chkCodes("R10 dispOff immediate");
    loadTick = 1'b1; leftIn = 1'b1; step(); leftIn = 1'b0;
    steps(4);
    chkCodes("R9 forced while shifting");
    loadTick = 1'b0;
    dispOff = 1'b0; #1;
    chkCodes("R9 released shows shift");
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    tReset();
    tShiftUp();
    tHold();
    tShiftDown();
    tSplit();
    tCodes();
    tDispOff();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule